// File: doc/BRIEF.md
# Display Data Channel Clock-Ratio Write Snooper

This block listens passively on the two-wire I2C link that a video source uses to configure a sink. It never drives either line. It follows every transaction, recognises a host write to the sink's status-and-control device (8-bit write address 0xA8, i.e. 7-bit 0x54), and tracks the register offset as bytes go by. When a data byte lands on offset 0x20, the block keeps bit 1 of that byte as the TMDS clock-ratio flag. The flag selects between two clock modes: clock at 1/10 of the bit rate, or clock at 1/40 of the bit rate.

The flag is cleared in two cases. The first is a hot-plug-detect input held low for a configurable time, 100 ms by default, with the time derived from the system clock frequency. The second is the loss of the host's +5 V presence input. Downstream logic reads the flag on a status port. A one-cycle change pulse tells that logic when to reapply its configuration.

Both bus lines pass through a two-flop synchronizer and a glitch filter. Line pulses shorter than the filter length never reach the frame tracker.

Top module: `ddc_ratio_snoop`

## Requirements
- R1: After reset, ratio_bit_o is 0, mode_div40_o is 0 (1/10 mode), status_byte_o is 0x00 and mode_chg_o is low.
- R2: A fully acknowledged write of address byte 0xA8, then offset 0x20, then a data byte, loads data bit 1 into ratio_bit_o. The other data bits are ignored. mode_div40_o equals ratio_bit_o, and status_byte_o carries the flag at bit 1 with every other bit 0.
- R3: Each data byte after the offset byte targets the next offset (8-bit auto-increment). Only a byte whose offset is 0x20 changes the flag.
- R4: A transaction whose address byte is not 0xA8 leaves the flag unchanged. This includes the read address 0xA9.
- R5: An acknowledge slot sampled high (NACK) after any byte abandons the transaction. That byte and every later byte up to the next START leave the flag unchanged.
- R6: A repeated START (SDA falling while SCL is high, inside a transaction) restarts address matching.
- R7: hpd_i held low for HPD_LOW_MS milliseconds clears the flag. A low period shorter than this has no effect, and any return of hpd_i to high restarts the timing.
- R8: While pwr5v_i is low, the flag is cleared and held at 0. Writes made during that time are lost.
- R9: mode_chg_o is high for exactly one cycle each time the flag changes, and at no other time.
- R10: A pulse on SCL shorter than FILT_LEN clock cycles is ignored by the bit sampler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, observed only |
| sda_i | input | 1 | Bus data line, observed only |
| hpd_i | input | 1 | Hot-plug detect level |
| pwr5v_i | input | 1 | Host +5 V presence |
| ratio_bit_o | output | 1 | Captured clock-ratio flag |
| mode_div40_o | output | 1 | 1 = clock at 1/40 of bit rate, 0 = 1/10 |
| mode_chg_o | output | 1 | One-cycle pulse when the flag changes |
| status_byte_o | output | 8 | Status read port, flag at bit 1, other bits 0 |

## Verification
A captured write shows on the flag outputs FILT_LEN+4 clock cycles after the raw SCL rise of the acknowledge slot that follows the data byte. These cycles are two synchronizer stages, FILT_LEN filter cycles, one tracker register and one status register. A fall of pwr5v_i clears the flag three cycles later. A fall of hpd_i clears it after the hot-plug window plus three cycles. The reference model in the bench changes its expected value only at the end of a settle window, which lasts longer than any of these delays. The every-clock comparison is suspended while a stimulus is in flight. The explicit hot-plug boundary checks are taken at ten cycles before the clear is due and at twenty cycles after it.

// File: rtl/ddc_snoop_pkg.sv
package ddc_snoop_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_OFFS,
        PH_DATA
    } phase_e;

    typedef struct packed {
        phase_e     ph;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [7:0] offs;
        logic       scl_p;
        logic       sda_p;
        logic       wr_stb;
        logic       wr_bit;
    } trk_s;

    typedef struct packed {
        logic pwr_s1;
        logic pwr_s2;
        logic ratio;
        logic chg;
    } top_s;

endpackage

// File: rtl/ddc_line_cond.sv
module ddc_line_cond #(
    parameter int   FILT_LEN = 3,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_s;

    flt_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2 != st_q.lvl) begin
            if (st_q.cnt == CW'(FILT_LEN - 1)) begin
                st_d.lvl = st_q.s2;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL, lvl: RST_VAL, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;

    // R10: the filtered level only moves to a value the synchronizer already held
    assert_filt_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> ($past(st_q.s2) == st_q.lvl));

endmodule

// File: rtl/ddc_frame_tracker.sv
module ddc_frame_tracker
    import ddc_snoop_pkg::*;
#(
    parameter logic [7:0] DEV_BYTE = 8'hA8,
    parameter logic [7:0] REG_OFFS = 8'h20,
    parameter int         BIT_IDX  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic wr_stb_o,
    output logic wr_bit_o
);
    trk_s st_d, st_q;
    logic start_ev, stop_ev, rise_ev;

    always_comb begin
        start_ev = st_q.scl_p && scl && st_q.sda_p && !sda;
        stop_ev  = st_q.scl_p && scl && !st_q.sda_p && sda;
        rise_ev  = !st_q.scl_p && scl;

        st_d        = st_q;
        st_d.scl_p  = scl;
        st_d.sda_p  = sda;
        st_d.wr_stb = 1'b0;

        if (start_ev) begin
            st_d.ph     = PH_ADDR;
            st_d.bitcnt = '0;
        end else if (stop_ev) begin
            st_d.ph     = PH_IDLE;
            st_d.bitcnt = '0;
        end else if (rise_ev && st_q.ph != PH_IDLE) begin
            if (st_q.bitcnt < 4'd8) begin
                st_d.shreg  = {st_q.shreg[6:0], sda};
                st_d.bitcnt = st_q.bitcnt + 4'd1;
            end else begin
                st_d.bitcnt = '0;
                if (sda) begin
                    st_d.ph = PH_IDLE;
                end else begin
                    unique case (st_q.ph)
                        PH_ADDR: st_d.ph = (st_q.shreg == DEV_BYTE) ? PH_OFFS : PH_IDLE;
                        PH_OFFS: begin
                            st_d.offs = st_q.shreg;
                            st_d.ph   = PH_DATA;
                        end
                        PH_DATA: begin
                            if (st_q.offs == REG_OFFS) begin
                                st_d.wr_stb = 1'b1;
                                st_d.wr_bit = st_q.shreg[BIT_IDX];
                            end
                            st_d.offs = st_q.offs + 8'd1;
                        end
                        default: st_d.ph = PH_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, bitcnt: '0, shreg: '0, offs: '0,
                      scl_p: 1'b1, sda_p: 1'b1, wr_stb: 1'b0, wr_bit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_stb_o = st_q.wr_stb;
    assign wr_bit_o = st_q.wr_bit;

    // R3: a flag update is only issued from the data phase
    assert_commit_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr_stb |-> ($past(st_q.ph) == PH_DATA));

    // R5: a high acknowledge slot leaves the tracker idle
    assert_nack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && !start_ev && st_q.ph != PH_IDLE && st_q.bitcnt == 4'd8 && sda)
        |=> (st_q.ph == PH_IDLE && !st_q.wr_stb));

endmodule

// File: rtl/hpd_loss_timer.sv
module hpd_loss_timer #(
    parameter int LIMIT = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hpd_i,
    output logic clr_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          fired;
        logic          clr;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = hpd_i;
        st_d.s2  = st_q.s1;
        st_d.clr = 1'b0;
        if (st_q.s2) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (!st_q.fired) begin
            if (st_q.cnt == CW'(LIMIT - 1)) begin
                st_d.fired = 1'b1;
                st_d.clr   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_o = st_q.clr;

    // R7: the clear is a single pulse
    assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |=> !st_q.clr);

    // R7: the clear only follows a low hot-plug level
    assert_clr_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.clr |-> !$past(st_q.s2));

endmodule

// File: rtl/ddc_ratio_snoop.sv
module ddc_ratio_snoop
    import ddc_snoop_pkg::*;
#(
    parameter int         CLK_HZ     = 100_000_000,
    parameter int         HPD_LOW_MS = 100,
    parameter int         FILT_LEN   = 3,
    parameter logic [7:0] DEV_BYTE   = 8'hA8,
    parameter logic [7:0] REG_OFFS   = 8'h20,
    parameter int         BIT_IDX    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       hpd_i,
    input  logic       pwr5v_i,
    output logic       ratio_bit_o,
    output logic       mode_div40_o,
    output logic       mode_chg_o,
    output logic [7:0] status_byte_o
);
    localparam int HPD_CYC = (CLK_HZ / 1000) * HPD_LOW_MS;
    localparam int NLINE   = 2;

    logic [NLINE-1:0] raw_lines;
    logic [NLINE-1:0] clean_lines;
    logic             wr_stb, wr_bit, hpd_clr;

    assign raw_lines = {sda_i, scl_i};

    for (genvar gi = 0; gi < NLINE; gi++) begin : g_line
        ddc_line_cond #(
            .FILT_LEN(FILT_LEN),
            .RST_VAL (1'b1)
        ) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[gi]),
            .level_o(clean_lines[gi])
        );
    end

    ddc_frame_tracker #(
        .DEV_BYTE(DEV_BYTE),
        .REG_OFFS(REG_OFFS),
        .BIT_IDX (BIT_IDX)
    ) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .wr_stb_o(wr_stb),
        .wr_bit_o(wr_bit)
    );

    hpd_loss_timer #(
        .LIMIT(HPD_CYC)
    ) u_hpd (
        .clk  (clk),
        .rst_n(rst_n),
        .hpd_i(hpd_i),
        .clr_o(hpd_clr)
    );

    top_s st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pwr_s1 = pwr5v_i;
        st_d.pwr_s2 = st_q.pwr_s1;
        if (!st_q.pwr_s2 || hpd_clr) begin
            st_d.ratio = 1'b0;
        end else if (wr_stb) begin
            st_d.ratio = wr_bit;
        end
        st_d.chg = (st_d.ratio != st_q.ratio);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_bit_o   = st_q.ratio;
    assign mode_div40_o  = st_q.ratio;
    assign mode_chg_o    = st_q.chg;
    assign status_byte_o = {7'b0, st_q.ratio} << BIT_IDX;

    // R8: a missing supply keeps the flag clear
    assert_pwr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pwr_s2 |=> !st_q.ratio);

    // R9: every flag change is flagged by the pulse
    assert_chg_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ratio != $past(st_q.ratio)) |-> st_q.chg);

    // R9: the pulse never fires without a change
    assert_chg_real_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.chg |-> (st_q.ratio != $past(st_q.ratio)));

    // R7: a hot-plug clear always wins over a concurrent write
    assert_hpd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_clr |=> !st_q.ratio);

endmodule

// File: tb/ddc_ratio_snoop_tb.sv
module ddc_ratio_snoop_tb;
    localparam int CLK_HZ = 100_000;
    localparam int HPD_MS = 100;
    localparam int LIM    = (CLK_HZ / 1000) * HPD_MS;
    localparam int H      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, hpd = 1'b1, pwr = 1'b1;
    logic       ratio_bit, mode40, chg;
    logic [7:0] status;

    int checks = 0, failures = 0, cyc = 0;
    int exp_ratio = 0, exp_chg = 0, seen_chg = 0;
    bit busy = 1'b1, done = 1'b0;
    logic [7:0] dq[$];

    always #5 clk = ~clk;

    ddc_ratio_snoop #(.CLK_HZ(CLK_HZ), .HPD_LOW_MS(HPD_MS), .FILT_LEN(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .hpd_i(hpd),
        .pwr5v_i(pwr), .ratio_bit_o(ratio_bit), .mode_div40_o(mode40),
        .mode_chg_o(chg), .status_byte_o(status));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference: compared on every clock when no stimulus is in flight
    always @(negedge clk) begin
        cyc++;
        if (rst_n && chg) seen_chg++;
        if (rst_n && !busy) begin
            check("R2 ratio_bit", int'(ratio_bit), exp_ratio);
            check("R2 mode_div40", int'(mode40), exp_ratio);
            check("R2 status_byte", int'(status), exp_ratio * 2);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_exp(input int v);
        if (v != exp_ratio) exp_chg++;
        exp_ratio = v;
        busy = 1'b0;
    endtask

    task automatic bus_start();
        sda = 1'b1; wait_n(H);
        scl = 1'b1; wait_n(H);
        sda = 1'b0; wait_n(H);
        scl = 1'b0; wait_n(H);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wait_n(H);
        scl = 1'b1; wait_n(H);
        sda = 1'b1; wait_n(H);
    endtask

    task automatic bus_bit(input logic b, input bit glitch);
        sda = b;
        if (glitch) begin
            wait_n(H / 2);
            scl = 1'b1; wait_n(1);
            scl = 1'b0; wait_n(H / 2 - 1);
        end else begin
            wait_n(H);
        end
        scl = 1'b1; wait_n(H);
        scl = 1'b0; wait_n(H);
    endtask

    task automatic bus_byte(input logic [7:0] b, input logic nack, input bit glitch);
        for (int i = 7; i >= 0; i--) bus_bit(b[i], glitch);
        bus_bit(nack, 1'b0);
    endtask

    // full write transaction plus the model's view of it; nack_at: 0 addr, 1 offset, 2+ data
    task automatic xfer(input logic [7:0] addr, input logic [7:0] offs, input int nack_at,
                        input bit glitch);
        int   nv    = exp_ratio;
        bit   alive = (addr == 8'hA8) && (nack_at != 0) && (nack_at != 1);
        logic [7:0] o;
        busy = 1'b1;
        for (int i = 0; i < dq.size(); i++) begin
            o = offs + 8'(i);
            if (nack_at == i + 2) alive = 1'b0;
            if (alive && o == 8'h20 && pwr) nv = int'(dq[i][1]);
        end
        if (!pwr) nv = 0;
        bus_start();
        bus_byte(addr, nack_at == 0, 1'b0);
        bus_byte(offs, nack_at == 1, 1'b0);
        for (int i = 0; i < dq.size(); i++) bus_byte(dq[i], nack_at == i + 2, glitch);
        bus_stop();
        wait_n(20);
        set_exp(nv);
        dq.delete();
    endtask

    task automatic write1(input logic [7:0] v);
        dq.push_back(v);
        xfer(8'hA8, 8'h20, 99, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= 180_000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 180_000);
            finish_run();
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        check("R1 ratio", int'(ratio_bit), 0);
        check("R1 mode", int'(mode40), 0);
        check("R1 status", int'(status), 0);
        check("R1 chg", int'(chg), 0);
        busy = 1'b0;

        // R2 basic writes, other bits ignored
        write1(8'h02); check("R2 set", int'(ratio_bit), 1);
        write1(8'h00); check("R2 clear", int'(ratio_bit), 0);
        write1(8'hFF); check("R2 ff", int'(status), 2);
        write1(8'hFD); check("R2 fd", int'(mode40), 0);

        // R3 auto-increment
        dq = '{8'h00, 8'h02};        xfer(8'hA8, 8'h1F, 99, 1'b0);
        check("R3 second byte hits 0x20", int'(ratio_bit), 1);
        dq = '{8'hFF, 8'h00, 8'h02}; xfer(8'hA8, 8'h1E, 99, 1'b0);
        check("R3 third byte hits 0x20", int'(ratio_bit), 1);
        dq = '{8'h00, 8'h02};        xfer(8'hA8, 8'h20, 99, 1'b0);
        check("R3 0x21 ignored", int'(ratio_bit), 0);
        dq = '{8'h02};               xfer(8'hA8, 8'h21, 99, 1'b0);
        check("R3 start at 0x21", int'(ratio_bit), 0);

        // R4 other addresses
        dq = '{8'h02}; xfer(8'hA9, 8'h20, 99, 1'b0);
        check("R4 read address", int'(ratio_bit), 0);
        dq = '{8'h02}; xfer(8'hB0, 8'h20, 99, 1'b0);
        check("R4 foreign address", int'(ratio_bit), 0);

        // R5 NACK abandons
        dq = '{8'h02}; xfer(8'hA8, 8'h20, 2, 1'b0);
        check("R5 data nack", int'(ratio_bit), 0);
        dq = '{8'h02}; xfer(8'hA8, 8'h20, 1, 1'b0);
        check("R5 offset nack", int'(ratio_bit), 0);
        dq = '{8'h02}; xfer(8'hA8, 8'h20, 0, 1'b0);
        check("R5 address nack", int'(ratio_bit), 0);
        dq = '{8'h00, 8'h02}; xfer(8'hA8, 8'h1F, 2, 1'b0);
        check("R5 later bytes dropped", int'(ratio_bit), 0);

        // R6 repeated START restarts matching
        busy = 1'b1;
        bus_start(); bus_byte(8'hA8, 1'b0, 1'b0); bus_byte(8'h20, 1'b0, 1'b0);
        bus_start(); bus_byte(8'hB0, 1'b0, 1'b0); bus_byte(8'h20, 1'b0, 1'b0);
        bus_byte(8'h02, 1'b0, 1'b0); bus_stop(); wait_n(20); set_exp(0);
        check("R6 restart to foreign", int'(ratio_bit), 0);
        busy = 1'b1;
        bus_start(); bus_byte(8'hB0, 1'b0, 1'b0);
        bus_start(); bus_byte(8'hA8, 1'b0, 1'b0); bus_byte(8'h20, 1'b0, 1'b0);
        bus_byte(8'h02, 1'b0, 1'b0); bus_stop(); wait_n(20); set_exp(1);
        check("R6 restart to match", int'(ratio_bit), 1);

        // R10 short SCL pulses ignored
        dq = '{8'h00}; xfer(8'hA8, 8'h20, 99, 1'b1);
        check("R10 glitched write clear", int'(ratio_bit), 0);
        dq = '{8'h02}; xfer(8'hA8, 8'h20, 99, 1'b1);
        check("R10 glitched write set", int'(ratio_bit), 1);

        // R7 hot-plug timer
        busy = 1'b1;
        hpd = 1'b0; wait_n(LIM - 100); hpd = 1'b1; wait_n(20);
        check("R7 short low", int'(ratio_bit), 1);
        hpd = 1'b0; wait_n(LIM - 100); hpd = 1'b1; wait_n(3);
        hpd = 1'b0; wait_n(LIM - 100); hpd = 1'b1; wait_n(20);
        check("R7 restart", int'(ratio_bit), 1);
        hpd = 1'b0; wait_n(LIM - 10);
        check("R7 before window", int'(ratio_bit), 1);
        wait_n(30);
        check("R7 after window", int'(ratio_bit), 0);
        hpd = 1'b1; wait_n(10); set_exp(0);
        check("R9 pulse count hpd", seen_chg, exp_chg);

        // R8 power loss
        write1(8'h02);
        busy = 1'b1; pwr = 1'b0; wait_n(10);
        check("R8 cleared", int'(ratio_bit), 0);
        set_exp(0);
        write1(8'h02);
        check("R8 write lost", int'(ratio_bit), 0);
        busy = 1'b1; pwr = 1'b1; wait_n(10); set_exp(0);
        check("R8 stays clear", int'(ratio_bit), 0);
        write1(8'h02);
        check("R8 recovered", int'(ratio_bit), 1);

        wait_n(10);
        check("R9 pulse count total", seen_chg, exp_chg);
        finish_run();
    end
endmodule